// File: doc/BRIEF.md
# Boot-Overlay Address Window Decoder

This block sits between a CPU's 24-bit byte address bus and the memories behind it. It splits the address space into 64 equal windows of 256 KiB, picked by the six top address bits. For each access it reports which memory the access goes to, the byte offset inside that memory, and whether the access is allowed or refused. A refused access gives a signal that the bus logic can turn into a bus error.

A boot overlay flag decides what sits at the bottom of the space. Reset sets the flag. While it is set, the 512 KiB boot ROM appears at address zero and can only be read, so the CPU fetches its start-up vectors from ROM. Startup code clears the flag through a control write. From then on, the 512 KiB work RAM is readable and writable at address zero, and it repeats four times up to 0x1FFFFF. The last window, from 0xFC0000 to the top of the space, always shows the ROM and can only be read.

Decoding is purely combinational from the address, the strobes and the registered overlay flag. Only the flag holds state.

Top module: `ovl_region_decoder`

## Requirements
- R1: While rst_n is low, the overlay flag is set. After reset is released, address 0x000000 decodes as boot ROM.
- R2: With the overlay set, reads of 0x000000–0x07FFFF give tgt_o=2 (ROM), permit_o=1 and offset_o = address bits [18:0]. Windows 2 to 7 (0x080000–0x1FFFFF) are unmapped.
- R3: With the overlay clear, reads and writes of 0x000000–0x1FFFFF give tgt_o=1 (RAM), permit_o=1 and offset_o = address bits [18:0]. Each 512 KiB repeat starts at RAM offset zero.
- R4: Reads of 0xFC0000–0xFFFFFF give tgt_o=2 (ROM), permit_o=1 and offset_o = address bits [17:0], whatever the overlay state.
- R5: A write to a read-only window, or any access to an unmapped window, gives deny_o=1, permit_o=0, tgt_o=0 and offset_o=0.
- R6: With rd_i=0 and wr_i=0, the outputs are tgt_o=0, offset_o=0, permit_o=0 and deny_o=0.
- R7: When ovl_we_i is high at a rising clock edge, the flag loads ovl_val_i. Decoding uses the new value from that edge on. Writing the value the flag already holds leaves the mapping unchanged.
- R8: The decode outputs follow the address and the strobes within the same cycle, with no register in the path.
- R9: When rd_i and wr_i are both high, the access is allowed only if the window permits both reading and writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay flag |
| addr_i | input | 24 | CPU byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ovl_we_i | input | 1 | Overlay control write enable |
| ovl_val_i | input | 1 | New overlay flag value (1 = ROM at zero) |
| tgt_o | output | 2 | Target: 0 none, 1 RAM, 2 ROM |
| offset_o | output | 19 | Byte offset inside the target |
| permit_o | output | 1 | Access is allowed |
| deny_o | output | 1 | Access is refused |

## Verification
The address decode results are due in the same cycle as the address and strobes. The bench drives these inputs on the falling clock edge and samples the outputs 1 ns later, well before the next rising edge. An overlay write takes effect only at the rising edge that samples ovl_we_i. The bench therefore checks once before that edge, to confirm the old mapping still holds, and again after the following falling edge, to confirm the new mapping. Reset is asynchronous, so the reset check samples while rst_n is still low.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  parameter int ADDR_W      = 24;
  parameter int WIN_W       = 6;
  parameter int RAM_AW      = 19;
  parameter int ROM_AW      = 19;
  parameter int RAM_MIRRORS = 4;

  localparam int NUM_WIN      = 1 << WIN_W;
  localparam int WIN_AW       = ADDR_W - WIN_W;
  localparam int OFF_W        = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW;
  localparam int ROM_LOW_WINS = (1 << ROM_AW) >> WIN_AW;
  localparam int RAM_WINS     = ((1 << RAM_AW) >> WIN_AW) * RAM_MIRRORS;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic rd_ok;
    logic wr_ok;
    logic wide;   // 1: offset spans OFF_W bits, 0: a single window
  } win_attr_t;

  // Attribute of window w for a given overlay state.
  function automatic win_attr_t win_attr(input int w, input logic ovl);
    win_attr_t a;
    a = '{tgt: TGT_NONE, rd_ok: 1'b0, wr_ok: 1'b0, wide: 1'b0};
    if (w == NUM_WIN - 1) begin
      a = '{tgt: TGT_ROM, rd_ok: 1'b1, wr_ok: 1'b0, wide: 1'b0};
    end else if (ovl && (w < ROM_LOW_WINS)) begin
      a = '{tgt: TGT_ROM, rd_ok: 1'b1, wr_ok: 1'b0, wide: 1'b1};
    end else if (!ovl && (w < RAM_WINS)) begin
      a = '{tgt: TGT_RAM, rd_ok: 1'b1, wr_ok: 1'b1, wide: 1'b1};
    end
    return a;
  endfunction

  // Offset relative to the start of the mapped range.
  function automatic logic [OFF_W-1:0] off_calc(input logic [OFF_W-1:0] low,
                                                input logic wide);
    logic [OFF_W-1:0] m;
    m = wide ? {OFF_W{1'b1}} : OFF_W'((1 << WIN_AW) - 1);
    return low & m;
  endfunction
endpackage

// File: rtl/ovl_flag_reg.sv
module ovl_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic val_i,
  output logic flag_o,
  output logic chg_o
);
  logic flag_q;

  assign chg_o = we_i && (val_i != flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else if (chg_o) begin
      flag_q <= val_i;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ovl_window_table.sv
module ovl_window_table
  import ovl_pkg::*;
(
  input  logic             ovl_i,
  input  logic [WIN_W-1:0] idx_i,
  output win_attr_t        attr_o
);
  win_attr_t tbl [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign tbl[g] = win_attr(g, ovl_i);
  end

  assign attr_o = tbl[idx_i];
endmodule

// File: rtl/ovl_access_check.sv
module ovl_access_check
  import ovl_pkg::*;
(
  input  logic [OFF_W-1:0] low_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  win_attr_t        attr_i,
  output tgt_e             tgt_o,
  output logic [OFF_W-1:0] off_o,
  output logic             permit_o,
  output logic             deny_o,
  output logic             ro_write_o,
  output logic             unmapped_o
);
  logic access;
  logic mapped;
  logic ok;

  assign access     = rd_i || wr_i;
  assign mapped     = (attr_i.tgt != TGT_NONE);
  assign unmapped_o = access && !mapped;
  assign ro_write_o = wr_i && mapped && !attr_i.wr_ok;
  assign ok         = access && mapped
                      && (!rd_i || attr_i.rd_ok)
                      && (!wr_i || attr_i.wr_ok);

  always_comb begin
    permit_o = ok;
    deny_o   = access && !ok;
    tgt_o    = ok ? attr_i.tgt : TGT_NONE;
    off_o    = ok ? off_calc(low_i, attr_i.wide) : '0;
  end
endmodule

// File: rtl/ovl_region_decoder.sv
module ovl_region_decoder
  import ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              ovl_we_i,
  input  logic              ovl_val_i,
  output logic [1:0]        tgt_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              permit_o,
  output logic              deny_o
);
  logic       ovl_flag;
  logic       ovl_chg;
  win_attr_t  cur_attr;
  tgt_e       tgt;
  logic       ro_write;
  logic       unmapped;

  ovl_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (ovl_we_i),
    .val_i  (ovl_val_i),
    .flag_o (ovl_flag),
    .chg_o  (ovl_chg)
  );

  ovl_window_table u_tbl (
    .ovl_i  (ovl_flag),
    .idx_i  (addr_i[ADDR_W-1 -: WIN_W]),
    .attr_o (cur_attr)
  );

  ovl_access_check u_chk (
    .low_i      (addr_i[OFF_W-1:0]),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .attr_i     (cur_attr),
    .tgt_o      (tgt),
    .off_o      (offset_o),
    .permit_o   (permit_o),
    .deny_o     (deny_o),
    .ro_write_o (ro_write),
    .unmapped_o (unmapped)
  );

  assign tgt_o = tgt;
endmodule

// File: rtl/ovl_region_decoder_sva.sv
module ovl_region_decoder_sva
  import ovl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              ovl_we_i,
  input logic              ovl_val_i,
  input logic [1:0]        tgt_o,
  input logic [OFF_W-1:0]  offset_o,
  input logic              permit_o,
  input logic              deny_o,
  input logic              ovl_flag,
  input logic              ro_write,
  input logic              unmapped
);
  localparam int RAM_TOP_BIT = RAM_AW + $clog2(RAM_MIRRORS);

  p_reset_sets_r1: assert property (@(posedge clk)
    !rst_n |=> ovl_flag);

  p_flag_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_we_i |=> (ovl_flag == $past(ovl_val_i)));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_we_i |=> $stable(ovl_flag));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit_o && deny_o));

  p_deny_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_write || unmapped) |-> (deny_o && tgt_o == 2'd0 && offset_o == '0));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !wr_i) |-> (!permit_o && !deny_o && tgt_o == 2'd0));

  p_top_rom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1 -: WIN_W] == '1 && rd_i && !wr_i) |->
      (permit_o && tgt_o == 2'd2));

  p_ram_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (permit_o && tgt_o == 2'd1) |->
      (!ovl_flag && (addr_i >> RAM_TOP_BIT) == '0));

  p_write_ram_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (permit_o && wr_i) |-> (tgt_o == 2'd1));
endmodule

bind ovl_region_decoder ovl_region_decoder_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .ovl_we_i  (ovl_we_i),
  .ovl_val_i (ovl_val_i),
  .tgt_o     (tgt_o),
  .offset_o  (offset_o),
  .permit_o  (permit_o),
  .deny_o    (deny_o),
  .ovl_flag  (ovl_flag),
  .ro_write  (ro_write),
  .unmapped  (unmapped)
);

// File: tb/ovl_region_decoder_tb.sv
`timescale 1ns/1ps
module ovl_region_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        ovl_we = 1'b0, ovl_val = 1'b0;
  logic [1:0]  tgt;
  logic [18:0] off;
  logic        permit, deny;

  int checks = 0;
  int errors = 0;
  logic model_ovl = 1'b1;

  always #2 clk = ~clk;   // 250 MHz

  ovl_region_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .ovl_we_i(ovl_we), .ovl_val_i(ovl_val),
    .tgt_o(tgt), .offset_o(off), .permit_o(permit), .deny_o(deny)
  );

  // Expected decode, derived from address ranges.
  function automatic logic [22:0] expect_of(input logic [23:0] a,
                                            input logic r, input logic w,
                                            input logic o);
    logic is_rom, is_ram, ok;
    logic [1:0] t;
    logic [18:0] of;
    is_rom = (a >= 24'hFC0000) || (o && a < 24'h080000);
    is_ram = !o && a < 24'h200000;
    ok = (r || w) && (is_rom || is_ram) && (!w || is_ram);
    t = !ok ? 2'd0 : (is_ram ? 2'd1 : 2'd2);
    if (!ok)                 of = '0;
    else if (a >= 24'hFC0000) of = 19'(a - 24'hFC0000);
    else                      of = 19'(a % 24'h080000);
    return {t, of, ok, (r || w) && !ok};
  endfunction

  task automatic check_access(input logic [23:0] a, input logic r,
                              input logic w, input string req);
    logic [22:0] exp, act;
    @(negedge clk);
    addr = a; rd = r; wr = w;
    #1;
    exp = expect_of(a, r, w, model_ovl);
    act = {tgt, off, permit, deny};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rd=%b wr=%b actual tgt=%0d off=%h p=%b d=%b expected tgt=%0d off=%h p=%b d=%b",
               req, a, r, w, act[22:21], act[20:2], act[1], act[0],
               exp[22:21], exp[20:2], exp[1], exp[0]);
    end
  endtask

  task automatic write_ovl(input logic v);
    @(negedge clk);
    ovl_we = 1'b1; ovl_val = v;
    @(negedge clk);
    ovl_we = 1'b0;
    model_ovl = v;
  endtask

  function automatic string tag_of(input logic [23:0] a, input logic w);
    if (a >= 24'hFC0000) return w ? "R5" : "R4";
    if (model_ovl) return (a < 24'h080000 && !w) ? "R2" : "R5";
    return (a < 24'h200000) ? "R3" : "R5";
  endfunction

  task automatic sweep_windows();
    for (int w = 0; w < 64; w++) begin
      for (int e = 0; e < 2; e++) begin
        logic [23:0] a;
        a = 24'(w * 24'h040000 + (e ? 24'h03FFFF : 24'h0));
        check_access(a, 1'b1, 1'b0, tag_of(a, 1'b0));
        check_access(a, 1'b0, 1'b1, tag_of(a, 1'b1));
      end
    end
  endtask

  task automatic t_reset_state();
    #1;
    check_access(24'h000000, 1'b1, 1'b0, "R1");
    check_access(24'h000004, 1'b0, 1'b1, "R1");
    @(negedge clk); rst_n = 1'b1;
    check_access(24'h000000, 1'b1, 1'b0, "R1");
  endtask

  task automatic t_idle();
    check_access(24'h000000, 1'b0, 1'b0, "R6");
    check_access(24'hFFFFFE, 1'b0, 1'b0, "R6");
    check_access(24'h400000, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_overlay_on();
    sweep_windows();
    check_access(24'h05A5A4, 1'b1, 1'b0, "R2");
    check_access(24'h05A5A4, 1'b1, 1'b1, "R9");
  endtask

  task automatic t_switch_timing();
    // Flag must not change before the capturing edge.
    @(negedge clk);
    ovl_we = 1'b1; ovl_val = 1'b0;
    addr = 24'h000010; rd = 1'b1; wr = 1'b0;
    #1;
    checks++;
    if (tgt !== 2'd2) begin
      errors++;
      $display("FAIL R7 early switch actual tgt=%0d expected tgt=2", tgt);
    end
    @(negedge clk);
    ovl_we = 1'b0;
    model_ovl = 1'b0;
    check_access(24'h000010, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_overlay_off();
    sweep_windows();
    check_access(24'h0ABCDE, 1'b1, 1'b0, "R3");
    check_access(24'h1ABCDE, 1'b0, 1'b1, "R3");
    check_access(24'h1ABCDE, 1'b1, 1'b1, "R9");
    check_access(24'hFC1234, 1'b1, 1'b1, "R9");
    // Same-cycle address change.
    check_access(24'h123456, 1'b1, 1'b0, "R8");
    check_access(24'h023456, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_same_value();
    write_ovl(1'b0);
    check_access(24'h000000, 1'b0, 1'b1, "R7");
    write_ovl(1'b1);
    write_ovl(1'b1);
    check_access(24'h000000, 1'b1, 1'b0, "R7");
    check_access(24'h080000, 1'b1, 1'b0, "R7");
    write_ovl(1'b0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    model_ovl = 1'b1;
    check_access(24'h000000, 1'b0, 1'b1, "R1");
    @(negedge clk); rst_n = 1'b1;
    check_access(24'h07FFFF, 1'b1, 1'b0, "R1");
    check_access(24'h100000, 1'b1, 1'b0, "R1");
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_idle();
    t_overlay_on();
    t_switch_timing();
    t_overlay_off();
    t_same_value();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule